// File: doc/BRIEF.md
# Terminal-Hold Binary Counter

This block is a small synchronous binary counter that advances by one step on every clock cycle in which its count-pulse enable is high. Once the count equals a stop value fixed at build time, further advancement is inhibited. The counter then holds that value for as long as it is left alone. A synchronous load or a synchronous reset is the only way out of the held state.

The counting direction is chosen by a parameter. In the up variant, reset clears the count to zero and the count climbs to the stop value. In the down variant, reset sets every bit to one and the count falls towards the stop value, which is zero by default.

The hold works by withholding the toggle enable from the least-significant stage, and from every stage above it, while the terminal value is decoded. The clock itself is never gated. A load strobe always wins over counting. It can restart a held counter at any value in a single cycle.

Top module: `ssc_hold_counter`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the count to zero in the up variant and to all ones in the down variant.
- R2: When `cnt_en_i` is high, `load_i` is low and the counter is not stopped, the count changes by exactly one step at the next edge: +1 in the up variant, -1 in the down variant, modulo 2^WIDTH.
- R3: When both `cnt_en_i` and `load_i` are low, the count keeps its value.
- R4: `stopped_o` is high in exactly those cycles in which `count_o` equals `STOP_VAL`, with no register delay. This includes the cycle right after a load of the stop value itself.
- R5: While the count equals `STOP_VAL` and `load_i` is low, `cnt_en_i` pulses have no effect: the count stays at the stop value. For example, a 3-bit down counter that starts at 7 reads 6,5,4,3,2,1,0 after seven pulses and is still 0 after the eighth.
- R6: When `load_i` is high at an edge, `count_o` takes `load_val_i`, whatever the states of `cnt_en_i` and `stopped_o`. A load releases a held counter whenever the new value differs from the stop value.
- R7: A counter loaded on the far side of the stop value keeps stepping through the wrap at the end of the range (15 to 0 for a 4-bit up counter) until it reaches the stop value. With a stop value of 10, a load of 12 therefore passes through 13, 14, 15, 0, ... 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Load strobe; takes priority over counting |
| load_val_i | input | WIDTH | Value written into the count on a load |
| cnt_en_i | input | 1 | Count-pulse enable, one step per high cycle |
| count_o | output | WIDTH | Present count |
| stopped_o | output | 1 | High while the count equals the stop value |

## Verification
The assertions check four behaviours on every cycle:
- the one-step advance while counting is enabled and the counter is not stopped;
- the hold when idle;
- the freeze at the terminal value;
- the load priority and the reset value.

Only the bench's scenarios show the sequences over many cycles. These are the full down run from all ones, which ends at zero and survives an extra pulse, and the up run through the wrap from 15 to 0. The bench also shows that a load of the stop value raises the flag at once, and that a reset in the middle of a run restores the starting value in both variants.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    // Counting direction of the terminal-hold counter
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

endpackage

// File: rtl/ssc_step.sv
// Next-value logic built as a chain of toggle enables, one per stage.
// Stage 0 toggles when 'advance' is high; stage i toggles when every
// lower stage is at its carry (up) or borrow (down) level.
module ssc_step #(
    parameter int          WIDTH = 4,
    parameter ssc_pkg::dir_e DIR = ssc_pkg::DIR_UP
) (
    input  logic [WIDTH-1:0] cnt_i,
    input  logic             advance_i,
    output logic [WIDTH-1:0] next_o
);

    logic [WIDTH-1:0] tog;

    assign tog[0] = advance_i;

    genvar gi;
    generate
        for (gi = 1; gi < WIDTH; gi++) begin : g_chain
            if (DIR == ssc_pkg::DIR_UP) begin : g_up
                assign tog[gi] = tog[gi-1] & cnt_i[gi-1];
            end else begin : g_dn
                assign tog[gi] = tog[gi-1] & ~cnt_i[gi-1];
            end
        end
    endgenerate

    assign next_o = cnt_i ^ tog;

endmodule

// File: rtl/ssc_term_detect.sv
// Bitwise match of the count against the fixed terminal value.
module ssc_term_detect #(
    parameter int               WIDTH    = 4,
    parameter logic [WIDTH-1:0] STOP_VAL = '0
) (
    input  logic [WIDTH-1:0] cnt_i,
    output logic             at_stop_o
);

    logic [WIDTH-1:0] match;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            assign match[gi] = ~(cnt_i[gi] ^ STOP_VAL[gi]);
        end
    endgenerate

    assign at_stop_o = &match;

endmodule

// File: rtl/ssc_hold_counter.sv
module ssc_hold_counter #(
    parameter int               WIDTH    = 4,
    parameter ssc_pkg::dir_e    DIR      = ssc_pkg::DIR_UP,
    parameter logic [WIDTH-1:0] STOP_VAL = (DIR == ssc_pkg::DIR_UP) ? WIDTH'(10) : '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    input  logic             cnt_en_i,
    output logic [WIDTH-1:0] count_o,
    output logic             stopped_o
);

    localparam logic [WIDTH-1:0] RST_VAL = (DIR == ssc_pkg::DIR_UP) ? '0 : '1;
    localparam logic [WIDTH-1:0] DELTA   = (DIR == ssc_pkg::DIR_UP) ? WIDTH'(1) : '1;

    typedef struct packed {
        logic [WIDTH-1:0] count;
    } state_t;

    state_t           state_d, state_q;
    logic             at_stop;
    logic             advance;
    logic [WIDTH-1:0] stepped;

    ssc_term_detect #(
        .WIDTH   (WIDTH),
        .STOP_VAL(STOP_VAL)
    ) term_i (
        .cnt_i    (state_q.count),
        .at_stop_o(at_stop)
    );

    // Terminal decode removes the toggle enable from stage 0 (and so all stages)
    assign advance = cnt_en_i & ~at_stop;

    ssc_step #(
        .WIDTH(WIDTH),
        .DIR  (DIR)
    ) step_i (
        .cnt_i    (state_q.count),
        .advance_i(advance),
        .next_o   (stepped)
    );

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.count = load_val_i;
        end else begin
            state_d.count = stepped;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.count <= RST_VAL;
        end else begin
            state_q <= state_d;
        end
    end

    assign count_o   = state_q.count;
    assign stopped_o = at_stop;

    // R1: reset value
    assert_reset_value_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count_o == RST_VAL));

    // R2: one step per enabled cycle
    assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt_en_i && !load_i && count_o != STOP_VAL) |=> (count_o == $past(count_o) + DELTA));

    // R3: idle hold
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en_i && !load_i) |=> $stable(count_o));

    // R5: frozen at terminal value
    assert_terminal_freeze_R5: assert property (@(posedge clk) disable iff (rst)
        (stopped_o && !load_i) |=> (stopped_o && $stable(count_o)));

    // R6: load priority
    assert_load_wins_R6: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (count_o == $past(load_val_i)));

endmodule

// File: tb/ssc_hold_counter_tb.sv
module ssc_hold_counter_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load = 1'b0;
    logic [3:0] load_val = '0;
    logic       en = 1'b0;

    logic [3:0] up_count;
    logic       up_stop;
    logic [2:0] dn_count;
    logic       dn_stop;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state
    int m_up = 0;
    int m_dn = 7;
    localparam int UP_STOP = 10;
    localparam int DN_STOP = 0;

    always #4 clk = ~clk;   // 125 MHz

    ssc_hold_counter #(
        .WIDTH(4), .DIR(ssc_pkg::DIR_UP), .STOP_VAL(4'd10)
    ) dut_i (
        .clk(clk), .rst(rst), .load_i(load), .load_val_i(load_val),
        .cnt_en_i(en), .count_o(up_count), .stopped_o(up_stop)
    );

    ssc_hold_counter #(
        .WIDTH(3), .DIR(ssc_pkg::DIR_DOWN), .STOP_VAL(3'd0)
    ) dut_dn_i (
        .clk(clk), .rst(rst), .load_i(load), .load_val_i(load_val[2:0]),
        .cnt_en_i(en), .count_o(dn_count), .stopped_o(dn_stop)
    );

    task automatic check(input string tag);
        checks++;
        if (int'(up_count) != m_up) begin
            errors++;
            $display("FAIL %s up count actual=%0d expected=%0d", tag, up_count, m_up);
        end
        checks++;
        if (int'(dn_count) != m_dn) begin
            errors++;
            $display("FAIL %s down count actual=%0d expected=%0d", tag, dn_count, m_dn);
        end
        checks++;
        if (up_stop != (m_up == UP_STOP) || dn_stop != (m_dn == DN_STOP)) begin
            errors++;
            $display("FAIL R4 (%s) stopped actual=%0b/%0b expected=%0b/%0b", tag,
                     up_stop, dn_stop, m_up == UP_STOP, m_dn == DN_STOP);
        end
    endtask

    // Compare the previous cycle's result, drive new inputs, advance the model
    task automatic cyc(input logic r, input logic ld, input int v, input logic e,
                       input string tag);
        @(negedge clk);
        check(tag);
        rst = r; load = ld; load_val = 4'(v); en = e;
        @(posedge clk);
        if (r) begin
            m_up = 0; m_dn = 7;
        end else begin
            if (ld) m_up = v % 16;
            else if (e && m_up != UP_STOP) m_up = (m_up + 1) % 16;
            if (ld) m_dn = v % 8;
            else if (e && m_dn != DN_STOP) m_dn = (m_dn + 7) % 8;
        end
    endtask

    initial begin
        fork
            begin
                // R1: reset state
                cyc(1, 0, 0, 1, "R1");
                cyc(1, 0, 0, 1, "R1");
                // R2/R5: free run; down stops at 0 after 7 pulses, 8th ignored
                for (int i = 0; i < 13; i++) cyc(0, 0, 0, 1, "R2");
                cyc(0, 0, 0, 1, "R5");
                cyc(0, 0, 0, 1, "R5");
                // R6: load while stopped and enabled
                cyc(0, 1, 3, 1, "R6");
                // R3: idle hold
                for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, "R3");
                // R2: alternating enable
                for (int i = 0; i < 6; i++) cyc(0, 0, 0, (i % 2) == 0, "R2");
                // R7: load beyond stop, wrap through 15 -> 0
                cyc(0, 1, 12, 0, "R7");
                for (int i = 0; i < 16; i++) cyc(0, 0, 0, 1, "R7");
                // R4: load stop value, flag immediately
                cyc(0, 1, 10, 1, "R4");
                cyc(0, 0, 0, 1, "R4");
                cyc(0, 1, 0, 0, "R4");
                cyc(0, 0, 0, 1, "R5");
                // R6: load at same time as enable in running counter
                cyc(0, 1, 5, 1, "R6");
                cyc(0, 0, 0, 1, "R2");
                cyc(0, 0, 0, 1, "R2");
                // R1: reset in the middle of a run
                cyc(1, 0, 0, 1, "R1");
                cyc(0, 0, 0, 1, "R1");
                cyc(0, 0, 0, 0, "R3");
                @(negedge clk);
                check("R3");
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule